// File: doc/BRIEF.md
# Sleep-Mode Wake Source Controller

This block monitors pins and internal requests while the processor is held in reset during a sleep-type power mode. Every source has its own trigger rule: a high level, a rising edge, or a change in either direction. Pin inputs pass through a two-flop synchronizer and then a noise filter, which accepts a new pin value only after it has stayed stable for a set number of fast sampling-clock cycles. A shared optical/general pin has two behaviours, chosen by a configuration bit. With the bit set, the pin must stay high for a number of slow-clock ticks. With the bit clear, the pin uses the short filter and triggers on any change.

A source is qualified when its enable bit is set, or when it is one of the always-enabled reset sources. A qualified source that fires during sleep raises `wake_o`. The processor reset is then released on the next slow-clock tick. A flag for the source is latched so firmware can find the cause of the wake. The push-button flag also latches when the system is awake. A rising power-good input during sleep causes a wake but sets no flag, and power-good can be read as a status bit. A watchdog-clear pulse is produced on each release from sleep and when firmware writes a command bit.

The fast clock `clk` drives everything. The slow clock is given as a one-cycle enable `slow_tick`.

Top module: `wake_ctl`

## Requirements
- R1: After reset, the flags read as zero, the configuration reads as zero, `wake_o` and `wdt_clr` are low, and with `sleep` low `cpu_rst_n` is high.
- R2: A filtered pin takes a new value only after that value has been present at the synchronizer output for SHORT_CNT consecutive clock cycles. A shorter pulse causes no wake and sets no flag.
- R3: The trigger rules are fixed. The button (`pins_i[0]`) and gpb (`pins_i[3]`) trigger on a high level. Rx (`pins_i[1]`) triggers on either edge. Gpa (`pins_i[2]`) triggers on a rising edge only, so a falling edge has no effect.
- R4: When config bit 6 is 1, the opt pin (`pins_i[4]`) triggers only after it has been high for LONG_CNT slow ticks, and a shorter high period has no effect. When config bit 6 is 0, it triggers on either edge using the short filter.
- R5: Config bits 0 to 4 enable button, rx, gpa, gpb and opt, and config bit 5 arms the timer input `tmr_i`. External reset (`pins_i[5]`), the software request `sw_rst_i` and debug reset (`pins_i[6]`) are always enabled. A disabled source neither wakes the processor nor sets a flag.
- R6: Detection acts only while `sleep` is 1. While `sleep` is 0, `wake_o` is low one cycle later, and sources other than the button leave the flags unchanged.
- R7: While `sleep` is 1, `cpu_rst_n` stays low until the first `slow_tick` that arrives with `wake_o` high. It goes high on the following clock edge, which is within three slow-clock cycles of the wake.
- R8: The flags are read at register select 1, bits 8:0, in this order: button, rx, gpa, gpb, opt, timer, external reset, software reset, debug reset. Writing 1 to a flag bit clears it. If a set and a clear happen in the same cycle, the flag stays set.
- R9: While awake, each filtered rising edge on the button sets flag bit 0, whatever its enable bit holds.
- R10: A rising `pwr_good_i` during sleep raises `wake_o` and sets no flag. Bit 15 at register select 1 shows `pwr_good_i`.
- R11: `wdt_clr` pulses for one cycle on each release from sleep, and also in the cycle after a write to register select 0 with bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable, once per slow-clock period |
| sleep | input | 1 | High while in a sleep-type mode |
| pins_i | input | 7 | Wake pins: 0 button, 1 rx, 2 gpa, 3 gpb, 4 opt, 5 ext reset, 6 debug reset |
| tmr_i | input | 1 | Wake timer expiry (synchronous) |
| sw_rst_i | input | 1 | Software reset request (synchronous) |
| pwr_good_i | input | 1 | Main power stable |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects config, 1 selects flags/status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current `reg_sel` |
| wake_o | output | 1 | Wake has occurred during this sleep |
| cpu_rst_n | output | 1 | Processor reset, active low |
| wdt_clr | output | 1 | Watchdog clear pulse |

## Verification
A wrong filter count or a stuck filter state shows up a few cycles after the pin settles. The flag appears at `reg_rdata` too early, too late or not at all, and `wake_o` follows on the same edge. A wrong wake or release register shows up at `cpu_rst_n` or `wdt_clr` within one slow-tick period. A behavioural model tracks these outputs on every clock, so any divergence is caught in the cycle where it first appears.

// File: rtl/wake_ctl.sv
module wake_ctl #(
  parameter int SHORT_CNT = 400,
  parameter int LONG_CNT  = 2097
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        sleep,
  input  logic [6:0]  pins_i,
  input  logic        tmr_i,
  input  logic        sw_rst_i,
  input  logic        pwr_good_i,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        wake_o,
  output logic        cpu_rst_n,
  output logic        wdt_clr
);
  localparam int SW = $clog2(SHORT_CNT + 1);
  localparam int LW = $clog2(LONG_CNT + 1);

  logic [6:0]    s1, s2, filt, filt_d;
  logic [SW-1:0] cnt [7];
  logic [LW-1:0] lcnt;
  logic [6:0]    cfg;
  logic [8:0]    flags, src, en, hit, setv, clr;
  logic          woke, run, pg_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; filt <= '0; filt_d <= '0; lcnt <= '0;
      for (int i = 0; i < 7; i++) cnt[i] <= '0;
    end else begin
      s1 <= pins_i;
      s2 <= s1;
      filt_d <= filt;
      for (int i = 0; i < 7; i++) begin
        if (s2[i] == filt[i]) cnt[i] <= '0;
        else if (cnt[i] == SW'(SHORT_CNT - 1)) begin
          filt[i] <= s2[i];
          cnt[i]  <= '0;
        end else cnt[i] <= cnt[i] + 1'b1;
      end
      if (!s2[4]) lcnt <= '0;
      else if (slow_tick && lcnt != LW'(LONG_CNT)) lcnt <= lcnt + 1'b1;
    end
  end

  wire [6:0] rise = filt & ~filt_d;
  wire [6:0] chg  = filt ^ filt_d;
  wire long_ok    = (lcnt == LW'(LONG_CNT));

  assign src  = {filt[6], sw_rst_i, filt[5], tmr_i, cfg[6] ? long_ok : chg[4],
                 filt[3], rise[2], chg[1], filt[0]};
  assign en   = {3'b111, cfg[5:0]};
  assign hit  = sleep ? (src & en) : '0;
  assign setv = hit | {8'b0, ~sleep & rise[0]};
  assign clr  = (reg_we && reg_sel) ? reg_wdata[8:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0; cfg <= '0; woke <= 1'b0; run <= 1'b0; pg_d <= 1'b0; wdt_clr <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | setv;
      if (reg_we && !reg_sel) cfg <= reg_wdata[6:0];
      pg_d <= pwr_good_i;
      if (!sleep) woke <= 1'b0;
      else if (|hit || (pwr_good_i && !pg_d)) woke <= 1'b1;
      if (!sleep) run <= 1'b0;
      else if (woke && slow_tick) run <= 1'b1;
      wdt_clr <= (sleep && woke && slow_tick && !run) ||
                 (reg_we && !reg_sel && reg_wdata[15]);
    end
  end

  assign wake_o    = woke;
  assign cpu_rst_n = ~sleep | run;
  assign reg_rdata = reg_sel ? {pwr_good_i, 6'b0, flags} : {9'b0, cfg};

  assert_awake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> !woke && !run);
  assert_release_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && woke && !run && slow_tick) |=> (run || !sleep));
  assert_release_needs_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(woke));
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_sel) |=> ((flags & $past(flags)) == $past(flags)));
  assert_release_clears_wdt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> wdt_clr);
endmodule

// File: tb/wake_ctl_test.sv
module wake_ctl_test;
  localparam int SHORT = 4;
  localparam int LONG  = 6;

  logic clk = 0, rst_n = 0, slow_tick = 0, sleep = 0;
  logic [6:0] pins = '0;
  logic tmr = 0, swr = 0, pg = 1, we = 0, sel = 1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic wake, crn, wdt;

  wake_ctl #(.SHORT_CNT(SHORT), .LONG_CNT(LONG)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sleep(sleep), .pins_i(pins),
    .tmr_i(tmr), .sw_rst_i(swr), .pwr_good_i(pg), .reg_we(we), .reg_sel(sel),
    .reg_wdata(wdata), .reg_rdata(rdata), .wake_o(wake), .cpu_rst_n(crn), .wdt_clr(wdt));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tickcnt = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit [6:0] m_s1, m_s2, m_acc, m_prev;
  int m_age [7];
  int m_lage;
  bit [6:0] m_cfg;
  bit [8:0] m_flags;
  bit m_woke, m_run, m_pg, m_wdt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_acc = 0; m_prev = 0; m_lage = 0;
      foreach (m_age[i]) m_age[i] = 0;
      m_cfg = 0; m_flags = 0; m_woke = 0; m_run = 0; m_pg = 0; m_wdt = 0;
    end else begin
      bit [8:0] fire, nf;
      bit any;
      for (int k = 0; k < 9; k++) begin
        bit f, e;
        case (k)
          0: f = m_acc[0];
          1: f = m_acc[1] != m_prev[1];
          2: f = m_acc[2] && !m_prev[2];
          3: f = m_acc[3];
          4: f = m_cfg[6] ? (m_lage == LONG) : (m_acc[4] != m_prev[4]);
          5: f = tmr;
          6: f = m_acc[5];
          7: f = swr;
          default: f = m_acc[6];
        endcase
        e = (k >= 6) ? 1'b1 : m_cfg[k];
        fire[k] = sleep && f && e;
      end
      any = |fire;
      nf = m_flags;
      if (we && sel) nf = nf & ~wdata[8:0];
      nf = nf | fire;
      if (!sleep && m_acc[0] && !m_prev[0]) nf[0] = 1;
      m_wdt = (sleep && m_woke && slow_tick && !m_run) || (we && !sel && wdata[15]);
      if (!sleep) m_run = 0; else if (m_woke && slow_tick) m_run = 1;
      if (!sleep) m_woke = 0; else if (any || (pg && !m_pg)) m_woke = 1;
      m_pg = pg;
      m_flags = nf;
      if (we && !sel) m_cfg = wdata[6:0];
      m_prev = m_acc;
      for (int i = 0; i < 7; i++) begin
        if (m_s2[i] == m_acc[i]) m_age[i] = 0;
        else if (m_age[i] + 1 >= SHORT) begin m_acc[i] = m_s2[i]; m_age[i] = 0; end
        else m_age[i]++;
      end
      if (!m_s2[4]) m_lage = 0;
      else if (slow_tick && m_lage < LONG) m_lage++;
      m_s2 = m_s1;
      m_s1 = pins;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tickcnt = (tickcnt + 1) % 8;
    slow_tick <= (tickcnt == 7);
    if (rst_n) begin
      chk({cur_req, " model wake"}, wake, m_woke);
      chk({cur_req, " model cpu_rst_n"}, crn, !sleep || m_run);
      chk({cur_req, " model wdt_clr"}, wdt, m_wdt);
      chk({cur_req, " model rdata"}, rdata,
          sel ? {pg, 6'b0, m_flags} : {9'b0, m_cfg});
    end
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit s, logic [15:0] d);
    we = 1; sel = s; wdata = d;
    @(negedge clk);
    we = 0; sel = 1; wdata = '0;
  endtask

  initial begin
    wait_n(5);
    rst_n = 1;
    wait_n(2);
    cur_req = "R1";
    chk("R1 wake", wake, 0);
    chk("R1 cpu_rst_n", crn, 1);
    chk("R1 wdt", wdt, 0);
    chk("R1 flags/status", rdata, 16'h8000);
    sel = 0; #0.1; chk("R1 cfg", rdata, 0); sel = 1;

    cur_req = "R2";
    wr(0, 16'h0007);
    sleep = 1; wait_n(3);
    chk("R7 held in reset", crn, 0);
    pins[0] = 1; wait_n(2); pins[0] = 0; wait_n(20);
    chk("R2 short pulse flags", rdata, 16'h8000);
    chk("R2 short pulse wake", wake, 0);
    cur_req = "R3";
    pins[0] = 1; wait_n(12);
    chk("R3 button level wake", wake, 1);
    cur_req = "R7";
    wait_n(20);
    chk("R7 released", crn, 1);
    chk("R3 button flag", rdata[8:0], 9'h001);
    pins[0] = 0; sleep = 0; wait_n(2);
    cur_req = "R8";
    wr(1, 16'h0001); wait_n(8);
    chk("R8 w1c", rdata[8:0], 0);

    cur_req = "R3";
    sleep = 1; pins[2] = 1; wait_n(20);
    chk("R3 gpa rise flag", rdata[8:0], 9'h004);
    sleep = 0; wr(1, 16'h0004); wait_n(2);
    sleep = 1; pins[2] = 0; wait_n(20);
    chk("R3 gpa fall ignored", rdata[8:0], 0);
    chk("R3 gpa fall no wake", wake, 0);
    pins[1] = 1; wait_n(20);
    chk("R3 rx edge flag", rdata[8:0], 9'h002);
    chk("R3 rx edge wake", wake, 1);
    sleep = 0; wr(1, 16'h0002); wait_n(4);

    cur_req = "R5";
    sleep = 1; pins[3] = 1; wait_n(20);
    chk("R5 gpb disabled", rdata[8:0], 0);
    chk("R5 gpb disabled wake", wake, 0);
    tmr = 1; wait_n(1); tmr = 0; wait_n(5);
    chk("R5 timer unarmed", rdata[8:0], 0);
    wr(0, 16'h0027);
    tmr = 1; wait_n(1); tmr = 0; wait_n(5);
    chk("R5 timer armed", rdata[8:0], 9'h020);
    sleep = 0; wr(1, 16'h0020); wait_n(2);
    sleep = 1; swr = 1; wait_n(1); swr = 0; wait_n(5);
    chk("R5 sw reset always on", rdata[8:0], 9'h080);
    sleep = 0; wr(1, 16'h0080); pins[3] = 0; wait_n(10);

    cur_req = "R4";
    wr(0, 16'h0050);
    sleep = 1; pins[4] = 1; wait_n(20); pins[4] = 0; wait_n(10);
    chk("R4 long filter short high", rdata[8:0], 0);
    pins[4] = 1; wait_n(80);
    chk("R4 long filter held", rdata[8:0], 9'h010);
    chk("R4 long wake", wake, 1);
    sleep = 0; pins[4] = 0; wr(1, 16'h0010); wr(0, 16'h0010); wait_n(10);
    sleep = 1; pins[4] = 1; wait_n(15);
    chk("R4 edge mode", rdata[8:0], 9'h010);
    sleep = 0; wr(1, 16'h0010); pins[4] = 0; wait_n(10);

    cur_req = "R9";
    pins[0] = 1; wait_n(10);
    chk("R9 awake button flag", rdata[8:0], 9'h001);
    cur_req = "R6";
    pins[3] = 1; pins[1] = 0; wait_n(20);
    chk("R6 awake others ignored", rdata[8:0], 9'h001);
    chk("R6 awake no wake", wake, 0);
    wr(1, 16'h0001); pins[0] = 0; pins[3] = 0; wait_n(10);

    cur_req = "R8";
    wr(0, 16'h0020);
    sleep = 1; wait_n(2);
    tmr = 1; we = 1; sel = 1; wdata = 16'h0020;
    @(negedge clk);
    tmr = 0; we = 0; wdata = 0;
    wait_n(3);
    chk("R8 set wins over clear", rdata[8:0], 9'h020);
    sleep = 0; wr(1, 16'h0020); wait_n(4);

    cur_req = "R10";
    pg = 0; wait_n(5);
    sleep = 1; wait_n(3);
    pg = 1; wait_n(3);
    chk("R10 power wake", wake, 1);
    chk("R10 no flag, status", rdata, 16'h8000);
    wait_n(20);
    chk("R7 power release", crn, 1);
    sleep = 0; wait_n(4);

    cur_req = "R11";
    wr(0, 16'h8000);
    chk("R11 firmware wdt clear", wdt, 1);
    wait_n(1);
    chk("R11 pulse one cycle", wdt, 0);
    wait_n(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule